// File: doc/BRIEF.md
# Coprocessor Response Sequencer

This block sits on the main-processor side of a coprocessor link. When a coprocessor instruction begins, it reads a 16-bit response word from the coprocessor's response register over a simple register port. It looks at three option bits in the top of that word. Then, in a fixed order, it writes the instruction address to the coprocessor, hands the primitive to a service unit or enters an exception, and either reads the response register again or finishes.

The sequencer is a six-state machine. The states are IDLE, READ_RESP, PASS_PC, SERVICE, EXCEPTION and DONE, and the transitions are:
- IDLE → READ_RESP on `start`. The instruction address is captured at this point.
- READ_RESP → PASS_PC on an acknowledged read whose PC bit is set.
- READ_RESP → SERVICE on an acknowledged read of a defined, well-formed primitive with PC clear.
- READ_RESP → EXCEPTION on an acknowledged read of any other primitive with PC clear.
- PASS_PC → SERVICE or EXCEPTION, once the address write is acknowledged, by the same decode.
- SERVICE → READ_RESP when the service completes and CA is set.
- SERVICE → DONE when the service completes and CA is clear.
- EXCEPTION → IDLE and DONE → IDLE, each after one cycle.

Several primitives can be chained within one instruction by setting CA in each of them.

Top module: `cop_resp_seq`

## Requirements
- R1: After reset the sequencer is idle, and `bus_req`, `svc_req`, `exc_valid` and `done` are all low.
- R2: A `start` pulse starts a read of the response register (`bus_sel`=0, `bus_we`=0). The request is held with a stable direction and selector until `bus_ack` is seen, for any number of wait cycles.
- R3: When bit 14 (PC) of a response word is set, the first action after the read is a write (`bus_we`=1, `bus_sel`=1) of the instruction address that was captured at `start`.
- R4: The PC write of R3 also happens when the primitive leads to an exception, and it completes before `exc_valid` rises.
- R5: The primitive type is bits 12:8. Type 0 (null), type 1 (release) and type 2 (operand transfer) are defined. A defined, well-formed primitive raises `svc_req` with `svc_code` equal to bits 12:0, held until `svc_done`.
- R6: `svc_dir` equals bit 13 (DR) of the word being serviced. A 1 means the transfer goes from the coprocessor to the main processor.
- R7: When bit 15 (CA) is set and the service completes, the next action is a new read of the response register.
- R8: When CA is clear and the service completes, `done` pulses for exactly one cycle and the sequencer returns to idle.
- R9: A word whose type is not 0, 1 or 2 gives a one-cycle `exc_valid` with `exc_kind`=0 (emulation), and no service request.
- R10: A release with CA set, or an operand transfer whose length (bits 7:0) is zero, gives a one-cycle `exc_valid` with `exc_kind`=1 (protocol violation), and no service request.
- R11: At most one of `bus_req`, `svc_req`, `exc_valid` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a coprocessor instruction |
| instr_addr | input | AW | Address of the instruction's operation word |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 2 | Register select: 0 response, 1 instruction address |
| bus_wdata | output | AW | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 16 | Read data (response word) |
| svc_req | output | 1 | Service request |
| svc_code | output | 13 | Primitive-specific bits of the word |
| svc_dir | output | 1 | Transfer direction (DR bit) |
| svc_done | input | 1 | Service complete |
| exc_valid | output | 1 | Exception entry pulse |
| exc_kind | output | 1 | 0 emulation, 1 protocol violation |
| done | output | 1 | Instruction finished pulse |

## Verification
Assertions check the following on every cycle:
- A pending request stays stable until it is acknowledged.
- A word with PC set is always followed directly by the address write.
- CA chooses between a new read and `done`.
- Exception and done pulses last one cycle.
- At most one activity is under way at a time.

Only the bench's scenarios can show the order of whole event streams: the value written, the codes and directions that reach the service unit, chains of several words, and which exception kind each malformed or undefined word produces.

// File: rtl/cps_pkg.sv
package cps_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_READ_RESP, S_PASS_PC, S_SERVICE, S_EXCEPTION, S_DONE
    } cps_state_t;

    localparam int WORD_W   = 16;
    localparam int CODE_W   = 13;
    localparam int BIT_CA   = 15;
    localparam int BIT_PC   = 14;
    localparam int BIT_DR   = 13;

    localparam logic [1:0] SEL_RESP  = 2'd0;
    localparam logic [1:0] SEL_IADDR = 2'd1;

    localparam logic [4:0] TY_NULL    = 5'd0;
    localparam logic [4:0] TY_RELEASE = 5'd1;
    localparam logic [4:0] TY_XFER    = 5'd2;

    localparam logic EXC_EMUL  = 1'b0;
    localparam logic EXC_PROTO = 1'b1;
endpackage

// File: rtl/cps_decode.sv
module cps_decode
    import cps_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              ok,
    output logic              kind
);
    logic [4:0] ty;
    logic [7:0] len;

    always_comb begin
        ty   = word[12:8];
        len  = word[7:0];
        ok   = 1'b0;
        kind = EXC_EMUL;
        unique case (ty)
            TY_NULL: ok = 1'b1;
            TY_RELEASE: begin
                ok   = !word[BIT_CA];
                kind = EXC_PROTO;
            end
            TY_XFER: begin
                ok   = (len != 8'd0);
                kind = EXC_PROTO;
            end
            default: begin
                ok   = 1'b0;
                kind = EXC_EMUL;
            end
        endcase
    end
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
    import cps_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     instr_addr,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              svc_done,
    input  logic              dec_ok,
    input  logic              dec_kind,
    output logic [WORD_W-1:0] dec_word,
    output cps_state_t        state,
    output logic [WORD_W-1:0] word_q,
    output logic [AW-1:0]     ia_q
);
    cps_state_t nxt;

    assign dec_word = (state == S_READ_RESP) ? bus_rdata : word_q;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (start) nxt = S_READ_RESP;
            S_READ_RESP: if (bus_ack) begin
                if (bus_rdata[BIT_PC]) nxt = S_PASS_PC;
                else                   nxt = dec_ok ? S_SERVICE : S_EXCEPTION;
            end
            S_PASS_PC:   if (bus_ack) nxt = dec_ok ? S_SERVICE : S_EXCEPTION;
            S_SERVICE:   if (svc_done) nxt = word_q[BIT_CA] ? S_READ_RESP : S_DONE;
            S_EXCEPTION: nxt = S_IDLE;
            S_DONE:      nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            word_q <= '0;
            ia_q   <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start)     ia_q   <= instr_addr;
            if (state == S_READ_RESP && bus_ack) word_q <= bus_rdata;
        end
    end

    logic unused_kind;
    assign unused_kind = dec_kind;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_READ_RESP || state == S_PASS_PC) && !bus_ack) |=> $stable(state)); // R2
    AST_PC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ_RESP && bus_ack && bus_rdata[BIT_PC]) |=> state == S_PASS_PC); // R3
    AST_CA_REREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SERVICE && svc_done && word_q[BIT_CA]) |=> state == S_READ_RESP); // R7
    AST_NOCA_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SERVICE && svc_done && !word_q[BIT_CA]) |=> state == S_DONE); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |=> state == S_IDLE); // R8
    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXCEPTION) |=> state == S_IDLE); // R9
endmodule

// File: rtl/cps_outdrv.sv
module cps_outdrv
    import cps_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cps_state_t        state,
    input  logic [WORD_W-1:0] word_q,
    input  logic [AW-1:0]     ia_q,
    input  logic              dec_kind,
    input  logic              bus_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_sel,
    output logic [AW-1:0]     bus_wdata,
    output logic              svc_req,
    output logic [CODE_W-1:0] svc_code,
    output logic              svc_dir,
    output logic              exc_valid,
    output logic              exc_kind,
    output logic              done
);
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_sel   = SEL_RESP;
        bus_wdata = '0;
        svc_req   = 1'b0;
        svc_code  = '0;
        svc_dir   = 1'b0;
        exc_valid = 1'b0;
        exc_kind  = EXC_EMUL;
        done      = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_READ_RESP: bus_req = 1'b1;
            S_PASS_PC: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_sel   = SEL_IADDR;
                bus_wdata = ia_q;
            end
            S_SERVICE: begin
                svc_req  = 1'b1;
                svc_code = word_q[CODE_W-1:0];
                svc_dir  = word_q[BIT_DR];
            end
            S_EXCEPTION: begin
                exc_valid = 1'b1;
                exc_kind  = dec_kind;
            end
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req, svc_req, exc_valid, done})); // R11
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_sel))); // R2
    AST_EXC_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !exc_valid && !svc_req); // R9
endmodule

// File: rtl/cop_resp_seq.sv
module cop_resp_seq
    import cps_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] instr_addr,
    output logic          bus_req,
    output logic          bus_we,
    output logic [1:0]    bus_sel,
    output logic [AW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [15:0]   bus_rdata,
    output logic          svc_req,
    output logic [12:0]   svc_code,
    output logic          svc_dir,
    input  logic          svc_done,
    output logic          exc_valid,
    output logic          exc_kind,
    output logic          done
);
    cps_state_t        state;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] dec_word;
    logic [AW-1:0]     ia_q;
    logic              dec_ok;
    logic              dec_kind;

    cps_decode u_dec (
        .word (dec_word),
        .ok   (dec_ok),
        .kind (dec_kind)
    );

    cps_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .instr_addr (instr_addr),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .svc_done   (svc_done),
        .dec_ok     (dec_ok),
        .dec_kind   (dec_kind),
        .dec_word   (dec_word),
        .state      (state),
        .word_q     (word_q),
        .ia_q       (ia_q)
    );

    cps_outdrv #(.AW(AW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .word_q    (word_q),
        .ia_q      (ia_q),
        .dec_kind  (dec_kind),
        .bus_ack   (bus_ack),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .svc_req   (svc_req),
        .svc_code  (svc_code),
        .svc_dir   (svc_dir),
        .exc_valid (exc_valid),
        .exc_kind  (exc_kind),
        .done      (done)
    );
endmodule

// File: tb/tb_cop_resp_seq.sv
module tb_cop_resp_seq;
    localparam int AW = 32;
    localparam int NV = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] instr_addr = '0;
    logic          bus_req, bus_we, svc_req, svc_dir, exc_valid, exc_kind, done;
    logic [1:0]    bus_sel;
    logic [AW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [15:0]   bus_rdata = '0;
    logic [12:0]   svc_code;
    logic          svc_done = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    cop_resp_seq #(.AW(AW)) dut (.*);

    // vector: {word0, word1, word2, wait_states}
    localparam logic [55:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 16'h0000, 8'd0},
        {16'h4205, 16'h0000, 16'h0000, 8'd2},
        {16'h2210, 16'h0000, 16'h0000, 8'd1},
        {16'hC000, 16'hA203, 16'h0100, 8'd3},
        {16'h0700, 16'h0000, 16'h0000, 8'd0},
        {16'h4900, 16'h0000, 16'h0000, 8'd1},
        {16'h8100, 16'h0000, 16'h0000, 8'd0},
        {16'h4200, 16'h0000, 16'h0000, 8'd2},
        {16'h8001, 16'h1F00, 16'h0000, 8'd0}
    };

    // event: {type[7:0], data[31:0]}; 1 read, 2 addr write, 3 service, 4 exception, 5 done, 7 bad bus
    logic [39:0] exp_e [16];
    string       exp_r [16];
    logic [39:0] got_e [16];

    task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic run(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                       input int ws, input logic [AW-1:0] addr);
        logic [15:0] words [3];
        int ne, ng, widx, wcnt, cyc;
        bit fin;
        words[0] = w0; words[1] = w1; words[2] = w2;
        ne = 0;
        fin = 0;
        for (int k = 0; k < 3 && !fin; k++) begin
            logic [15:0] w;
            logic [4:0] ty;
            bit ok, kind;
            w = words[k];
            exp_e[ne] = {8'd1, 32'd0}; exp_r[ne] = (k == 0) ? "R2" : "R7"; ne++;
            ty = w[12:8];
            ok = (ty == 5'd0) || (ty == 5'd1 && !w[15]) || (ty == 5'd2 && w[7:0] != 8'd0);
            kind = (ty == 5'd1 || ty == 5'd2);
            if (w[14]) begin
                exp_e[ne] = {8'd2, addr}; exp_r[ne] = ok ? "R3" : "R4"; ne++;
            end
            if (!ok) begin
                exp_e[ne] = {8'd4, 31'd0, kind}; exp_r[ne] = kind ? "R10" : "R9"; ne++;
                fin = 1;
            end else begin
                exp_e[ne] = {8'd3, 18'd0, w[13], w[12:0]}; exp_r[ne] = "R5_R6"; ne++;
                if (!w[15]) begin
                    exp_e[ne] = {8'd5, 32'd0}; exp_r[ne] = "R8"; ne++;
                    fin = 1;
                end
            end
        end

        @(negedge clk);
        instr_addr = addr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        instr_addr = '0;
        ng = 0; widx = 0; wcnt = 0; cyc = 0; fin = 0;
        while (!fin && cyc < 500 && ng < 16) begin
            bus_ack = 1'b0;
            svc_done = 1'b0;
            if ($countones({bus_req, svc_req, exc_valid, done}) > 1)
                check(0, "R11", {8'd0, 28'd0, bus_req, svc_req, exc_valid, done}, 40'd0);
            if (bus_req) begin
                if (wcnt >= ws) begin
                    wcnt = 0;
                    bus_ack = 1'b1;
                    if (!bus_we && bus_sel == 2'd0) begin
                        bus_rdata = (widx < 3) ? words[widx] : 16'h0000;
                        widx++;
                        got_e[ng] = {8'd1, 32'd0};
                    end else if (bus_we && bus_sel == 2'd1) got_e[ng] = {8'd2, bus_wdata};
                    else got_e[ng] = {8'd7, 29'd0, bus_we, bus_sel};
                    ng++;
                end else wcnt++;
            end else if (svc_req) begin
                if (wcnt >= ws) begin
                    wcnt = 0;
                    svc_done = 1'b1;
                    got_e[ng] = {8'd3, 18'd0, svc_dir, svc_code};
                    ng++;
                end else wcnt++;
            end else if (exc_valid) begin
                got_e[ng] = {8'd4, 31'd0, exc_kind}; ng++; fin = 1;
            end else if (done) begin
                got_e[ng] = {8'd5, 32'd0}; ng++; fin = 1;
            end
            cyc++;
            @(negedge clk);
        end
        bus_ack = 1'b0;
        svc_done = 1'b0;
        check(ng == ne && fin, "R2_sequence_length", 40'(ng), 40'(ne));
        for (int k = 0; k < ne; k++)
            check(k < ng && got_e[k] == exp_e[k], exp_r[k], (k < ng) ? got_e[k] : 40'd0, exp_e[k]);
        // after completion the block must be idle again (R8, R9)
        check(!bus_req && !svc_req && !exc_valid && !done, "R8_idle_after",
              {36'd0, bus_req, svc_req, exc_valid, done}, 40'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!bus_req && !svc_req && !exc_valid && !done, "R1",
              {36'd0, bus_req, svc_req, exc_valid, done}, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !svc_req && !exc_valid && !done, "R1",
              {36'd0, bus_req, svc_req, exc_valid, done}, 40'd0);

        for (int i = 0; i < NV; i++)
            run(VEC[i][55:40], VEC[i][39:24], VEC[i][23:8], int'(VEC[i][7:0]),
                32'h1000_0000 + 32'(i) * 32'h40);

        // Directed: long waits, three-word chain with PC on every word
        run(16'hC002, 16'hE204, 16'h4100, 20, 32'hDEAD_BEE0);
        // Directed: DR set on null with CA clear, no PC
        run(16'h2000, 16'h0000, 16'h0000, 0, 32'h0000_0004);
        // Directed: release with CA in a chain reached after a good word (R10)
        run(16'h8201, 16'h8100, 16'h0000, 1, 32'h0000_1234);

        // R1: reset in the middle of an access returns to idle
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!bus_req && !svc_req && !exc_valid && !done, "R1_midreset",
              {36'd0, bus_req, svc_req, exc_valid, done}, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req, "R1_midreset_idle", {39'd0, bus_req}, 40'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule